// File: doc/BRIEF.md
# Masked-Trigger Circular Capture Engine

This block is the recording core of a small logic analyzer. Every valid sample is turned into a 32-bit word: a 4-bit state field supplied by the caller and a 28-bit running count kept inside the block. The word is written into a 4096-slot circular buffer through a simple write port. Until a trigger fires, the buffer keeps being overwritten, so it always holds recent history.

When armed, each word is compared against a programmable mask and value. On a match, the block notes the slot just after the matching word. It then records a programmable number of further samples, stops writing and raises a done flag. A host reads the reported address, walks the buffer around that point to see the samples before and after the event, and then pulses restart to resume logging.

Top module: `trig_capture`

## Requirements
- R1: Reset sets done to 0, the write address to 0 and the trigger address to 0, and the block starts in the logging phase.
- R2: Each stored word is {state input in bits 31:28, running count in bits 27:0}. The running count starts at 0 after reset, advances by one on every valid sample (also while done) and wraps modulo 2^28.
- R3: The write address advances by one after each write and wraps from 4095 to 0.
- R4: A sample matches when every word bit whose mask bit is 1 equals the corresponding trigger value bit. Word bits whose mask bit is 0 are ignored.
- R5: No trigger is taken while the arm input is low.
- R6: On a trigger, the trigger address becomes the slot of the triggering word plus one, modulo 4096. The triggering word itself is written.
- R7: After the triggering word, exactly postCount further valid samples are written. The block then raises done in the next cycle and stops writing.
- R8: While done is high, valid samples are not written. A restart pulse while done clears done in the next cycle and logging resumes. A restart in any other phase is ignored.
- R9: Once triggered, further matches are ignored until restart, and the trigger address keeps its value until the next trigger.
- R10: A cycle with the valid strobe low writes nothing and leaves the write address and the running count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stateIn | input | 4 | State field of the current sample |
| sampleValid | input | 1 | Current sample is valid |
| armEn | input | 1 | Allows trigger detection |
| trigMask | input | 32 | 1 = compare this word bit |
| trigValue | input | 32 | Pattern the compared bits must equal |
| postCount | input | 12 | Number of samples to record after the trigger (intended 101..899) |
| restart | input | 1 | Clears done and resumes logging |
| wrEn | output | 1 | Buffer write strobe |
| wrAddr | output | 12 | Buffer write address |
| wrData | output | 32 | Buffer write word |
| done | output | 1 | Capture complete |
| trigAddr | output | 12 | Slot after the triggering word |

## Verification
The trigger is tried four ways:
- A full-state mask with the matching state repeated during the post-trigger run. This separates a first-match latch from one that re-arms.
- A partial mask where the sample differs from the value only in an ignored bit. This separates true masking from a plain equality test.
- A mask over the running-count field. This shows the count is packed and advances only on valid samples.
- A trigger placed in slot 4095. This shows the reported address wraps to 0.

An all-ignoring mask with arm low checks that arm gates detection. Restart pulses sent during logging and during the post-trigger run check that only the done phase reacts to restart.

// File: rtl/trig_capture_pkg.sv
package trig_capture_pkg;
  typedef enum logic [1:0] {
    PH_LOG  = 2'd0,
    PH_POST = 2'd1,
    PH_DONE = 2'd2
  } phase_t;

  typedef struct packed {
    logic write;
    logic trigLoad;
    logic cntDec;
  } ctrlStrobes_t;
endpackage

// File: rtl/trig_capture_dp.sv
module trig_capture_dp
  import trig_capture_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int STATE_W = 4,
  parameter int DATA_W  = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [STATE_W-1:0]  stateIn,
  input  logic                sampleValid,
  input  logic [DATA_W-1:0]   trigMask,
  input  logic [DATA_W-1:0]   trigValue,
  input  logic [ADDR_W-1:0]   postCount,
  input  ctrlStrobes_t        strobes,
  output logic                matchHit,
  output logic                postLast,
  output logic                postZero,
  output logic [ADDR_W-1:0]   wrAddr,
  output logic [DATA_W-1:0]   wrData,
  output logic [ADDR_W-1:0]   trigAddr
);
  localparam int COUNT_W = DATA_W - STATE_W;

  logic [COUNT_W-1:0] runCount;
  logic [ADDR_W-1:0]  addrQ;
  logic [ADDR_W-1:0]  postCnt;
  logic [DATA_W-1:0]  word;
  logic [DATA_W-1:0]  bitOk;

  assign word = {stateIn, runCount};

  // per-bit compare: an ignored bit always passes
  for (genvar i = 0; i < DATA_W; i++) begin : g_cmp
    assign bitOk[i] = ~trigMask[i] | (word[i] == trigValue[i]);
  end

  assign matchHit = &bitOk;
  assign postLast = (postCnt == ADDR_W'(1));
  assign postZero = (postCount == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runCount <= '0;
      addrQ    <= '0;
      postCnt  <= '0;
      trigAddr <= '0;
    end else begin
      if (sampleValid)      runCount <= runCount + 1'b1;
      if (strobes.write)    addrQ    <= addrQ + 1'b1;
      if (strobes.trigLoad) begin
        trigAddr <= addrQ + 1'b1;
        postCnt  <= postCount;
      end else if (strobes.cntDec) begin
        postCnt  <= postCnt - 1'b1;
      end
    end
  end

  assign wrAddr = addrQ;
  assign wrData = word;
endmodule

// File: rtl/trig_capture_ctl.sv
module trig_capture_ctl
  import trig_capture_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         sampleValid,
  input  logic         armEn,
  input  logic         restart,
  input  logic         matchHit,
  input  logic         postLast,
  input  logic         postZero,
  output ctrlStrobes_t strobes,
  output logic         done
);
  phase_t phase, nextPhase;
  logic   wrStb, trigStb, decStb;

  assign wrStb   = sampleValid && (phase != PH_DONE);
  assign trigStb = wrStb && (phase == PH_LOG) && armEn && matchHit;
  assign decStb  = wrStb && (phase == PH_POST);

  always_comb begin
    nextPhase = phase;
    unique case (phase)
      PH_LOG:  if (trigStb) nextPhase = postZero ? PH_DONE : PH_POST;
      PH_POST: if (decStb && postLast) nextPhase = PH_DONE;
      PH_DONE: if (restart) nextPhase = PH_LOG;
      default: nextPhase = PH_LOG;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_LOG;
    else       phase <= nextPhase;
  end

  assign strobes = '{write: wrStb, trigLoad: trigStb, cntDec: decStb};
  assign done    = (phase == PH_DONE);
endmodule

// File: rtl/trig_capture.sv
module trig_capture
  import trig_capture_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int STATE_W = 4,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [STATE_W-1:0] stateIn,
  input  logic               sampleValid,
  input  logic               armEn,
  input  logic [DATA_W-1:0]  trigMask,
  input  logic [DATA_W-1:0]  trigValue,
  input  logic [ADDR_W-1:0]  postCount,
  input  logic               restart,
  output logic               wrEn,
  output logic [ADDR_W-1:0]  wrAddr,
  output logic [DATA_W-1:0]  wrData,
  output logic               done,
  output logic [ADDR_W-1:0]  trigAddr
);
  ctrlStrobes_t strobes;
  logic         matchHit, postLast, postZero;

  trig_capture_ctl u_ctl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .armEn(armEn),
    .restart(restart), .matchHit(matchHit), .postLast(postLast),
    .postZero(postZero), .strobes(strobes), .done(done)
  );

  trig_capture_dp #(.ADDR_W(ADDR_W), .STATE_W(STATE_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stateIn(stateIn), .sampleValid(sampleValid),
    .trigMask(trigMask), .trigValue(trigValue), .postCount(postCount),
    .strobes(strobes), .matchHit(matchHit), .postLast(postLast),
    .postZero(postZero), .wrAddr(wrAddr), .wrData(wrData), .trigAddr(trigAddr)
  );

  assign wrEn = strobes.write;
endmodule

// File: rtl/trig_capture_chk.sv
module trig_capture_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              sampleValid,
  input logic              armEn,
  input logic              restart,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              done,
  input logic [ADDR_W-1:0] trigAddr
);
  assert_no_write_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !wrEn);

  assert_restart_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (done && restart) |=> !done);

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(wrEn)) |-> (wrAddr == ADDR_W'($past(wrAddr) + 1'b1)));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(sampleValid)) |-> $stable(wrAddr));

  assert_no_write_invalid_R10: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |-> !wrEn);

  assert_trig_slot_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$stable(trigAddr)) |-> (trigAddr == ADDR_W'($past(wrAddr) + 1'b1)));

  assert_unarmed_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(armEn)) |-> $stable(trigAddr));

  assert_done_after_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $rose(done)) |-> $past(wrEn));
endmodule

bind trig_capture trig_capture_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .armEn(armEn),
  .restart(restart), .wrEn(wrEn), .wrAddr(wrAddr), .done(done),
  .trigAddr(trigAddr)
);

// File: tb/sim_trig_capture.sv
`timescale 1ns/1ps
module sim_trig_capture;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  stateIn = '0;
  logic        sampleValid = 1'b0;
  logic        armEn = 1'b0;
  logic [31:0] trigMask = '0;
  logic [31:0] trigValue = '0;
  logic [11:0] postCount = '0;
  logic        restart = 1'b0;
  logic        wrEn, done;
  logic [11:0] wrAddr, trigAddr;
  logic [31:0] wrData;

  always #10 clk = ~clk;

  trig_capture u0 (
    .clk(clk), .rstN(rstN), .stateIn(stateIn), .sampleValid(sampleValid),
    .armEn(armEn), .trigMask(trigMask), .trigValue(trigValue),
    .postCount(postCount), .restart(restart), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .done(done), .trigAddr(trigAddr)
  );

  typedef struct {
    logic        en;
    logic [11:0] a;
    logic [31:0] d;
    logic        dn;
    logic [11:0] ta;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;

  // configuration applied at the next driven cycle
  logic        cfgArm = 1'b0;
  logic [31:0] cfgMask = '0, cfgValue = '0;
  logic [11:0] cfgPost = '0;

  // reference model state
  int          mPhase = 0;
  logic [11:0] mAddr = '0, mTrig = '0, mCnt = '0;
  logic [27:0] mCount = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] st, input bit vld, input bit rs);
    exp_t        e;
    logic [31:0] word;
    bit          wr, hit;
    @(posedge clk);
    #2;
    stateIn = st; sampleValid = vld; restart = rs;
    armEn = cfgArm; trigMask = cfgMask; trigValue = cfgValue; postCount = cfgPost;
    word = {st, mCount};
    wr   = vld && (mPhase != 2);
    e.en = wr; e.a = mAddr; e.d = word; e.dn = (mPhase == 2); e.ta = mTrig;
    q.push_back(e);
    hit = (((word ^ cfgValue) & cfgMask) == 32'd0);
    if (vld) mCount++;
    case (mPhase)
      0: if (wr && cfgArm && hit) begin
           mTrig = mAddr + 12'd1;
           if (cfgPost == 0) mPhase = 2;
           else begin mPhase = 1; mCnt = cfgPost; end
         end
      1: if (wr) begin
           if (mCnt == 1) mPhase = 2;
           else mCnt--;
         end
      default: if (rs) mPhase = 0;
    endcase
    if (wr) mAddr++;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(wrEn === e.en, "R10 write strobe", {31'd0, wrEn}, {31'd0, e.en});
      if (e.en) begin
        chk(wrAddr === e.a, "R3 write address", {20'd0, wrAddr}, {20'd0, e.a});
        chk(wrData === e.d, "R2 write word", wrData, e.d);
      end
      chk(done === e.dn, "R7 done flag", {31'd0, done}, {31'd0, e.dn});
      chk(trigAddr === e.ta, "R9 trigger address", {20'd0, trigAddr}, {20'd0, e.ta});
    end
  end

  initial begin
    #(20ns * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] slot;
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    chk(done === 1'b0, "R1 done after reset", {31'd0, done}, 32'd0);
    chk(wrAddr === 12'd0, "R1 address after reset", {20'd0, wrAddr}, 32'd0);
    chk(trigAddr === 12'd0, "R1 trigger address after reset", {20'd0, trigAddr}, 32'd0);

    // unarmed, mask ignores everything; valid alternates
    for (int i = 0; i < 20; i++) step(4'(i), (i % 2) == 0, i == 7);
    step(0, 0, 0);
    @(negedge clk);
    chk(done === 1'b0 && trigAddr === 12'd0, "R5 no trigger unarmed", {20'd0, trigAddr}, 32'd0);
    chk(wrAddr === 12'd10, "R10 only valid samples written", {20'd0, wrAddr}, 32'd10);

    // run 1: full state mask, repeated matches in post run
    cfgArm = 1; cfgMask = 32'hF000_0000; cfgValue = 32'hA000_0000; cfgPost = 12'd150;
    for (int i = 0; i < 30; i++) step(4'((i % 9) + 1), 1, 0);
    slot = mAddr;
    step(4'hA, 1, 0);
    for (int k = 0; k < 150; k++) step((k % 3 == 0) ? 4'hA : 4'h3, 1, k == 40);
    step(0, 0, 0);
    @(negedge clk);
    chk(done === 1'b1, "R7 done after post count", {31'd0, done}, 32'd1);
    chk(trigAddr === slot + 12'd1, "R6 trigger address", {20'd0, trigAddr}, {20'd0, slot + 12'd1});
    chk(wrAddr === slot + 12'd151, "R7 post write count", {20'd0, wrAddr}, {20'd0, slot + 12'd151});
    for (int i = 0; i < 5; i++) step(4'hA, 1, 0);
    @(negedge clk);
    chk(wrAddr === slot + 12'd151, "R8 no writes while done", {20'd0, wrAddr}, {20'd0, slot + 12'd151});
    chk(trigAddr === slot + 12'd1, "R9 address held", {20'd0, trigAddr}, {20'd0, slot + 12'd1});
    step(0, 0, 1);
    step(0, 0, 0);
    @(negedge clk);
    chk(done === 1'b0, "R8 restart clears done", {31'd0, done}, 32'd0);

    // run 2: partial mask, ignored low state bit
    cfgMask = 32'hE000_0000; cfgValue = 32'hA000_0000; cfgPost = 12'd101;
    for (int i = 0; i < 5; i++) step(4'h2, 1, 0);
    slot = mAddr;
    step(4'hB, 1, 0);
    for (int k = 0; k < 101; k++) step(4'h0, 1, 0);
    step(0, 0, 0);
    @(negedge clk);
    chk(trigAddr === slot + 12'd1, "R4 masked bit ignored", {20'd0, trigAddr}, {20'd0, slot + 12'd1});
    chk(done === 1'b1, "R7 done run 2", {31'd0, done}, 32'd1);
    step(0, 0, 1);

    // run 3: trigger in last slot, address wraps
    cfgArm = 0;
    while (mAddr != 12'd4095) step(4'h1, 1, 0);
    cfgArm = 1; cfgMask = 32'hF000_0000; cfgValue = 32'hA000_0000; cfgPost = 12'd899;
    step(4'hA, 1, 0);
    for (int k = 0; k < 899; k++) step(4'h5, 1, 0);
    step(0, 0, 0);
    @(negedge clk);
    chk(trigAddr === 12'd0, "R3 R6 wrapped trigger address", {20'd0, trigAddr}, 32'd0);
    chk(wrAddr === 12'd899, "R3 wrapped write address", {20'd0, wrAddr}, 32'd899);
    step(0, 0, 1);

    // run 4: trigger on the running count field
    cfgMask = 32'h0FFF_FFFF; cfgValue = {4'h0, mCount + 28'd7}; cfgPost = 12'd120;
    slot = mAddr + 12'd7;
    for (int k = 0; k < 8; k++) step(4'h6, 1, 0);
    for (int k = 0; k < 120; k++) step(4'h6, 1, 0);
    step(0, 0, 0);
    @(negedge clk);
    chk(trigAddr === slot + 12'd1, "R2 count field trigger", {20'd0, trigAddr}, {20'd0, slot + 12'd1});
    chk(done === 1'b1, "R7 done run 4", {31'd0, done}, 32'd1);
    step(0, 0, 0);
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule